// File: doc/BRIEF.md
# Self-Checking Dual-Thread Modular Exponentiator

This block raises a base to an exponent modulo a modulus, processing the exponent from its least significant bit upwards. It keeps two running values: a power term that is squared on every pass and an accumulator that picks up the power term whenever the current exponent bit is one. The arithmetic is done by two multipliers and two modulo reduction units. One pass takes two clock cycles. In the first cycle both multipliers work. In the second cycle both reduction units work. This leaves each kind of unit idle in every other cycle.

Those idle slots carry a second thread that runs one cycle behind the first. In checking mode the second thread repeats the first thread's job. The unit pair that forms the power term for one thread forms the accumulator for the other, so a permanent fault in either pair shows up as a disagreement. After every pass the copies are compared, one cycle after the primary thread updates its state. A mismatch sets a sticky error flag. In dual mode the second thread runs an unrelated exponentiation with its own operands, which doubles the throughput, and no comparison is made. A stuck-at-one mask on one multiplier's product lets the self-check be exercised.

Top module: `paired_modexp`

## Requirements
- R1: Given k, `start` loads the operands. `done` then rises for a single cycle on the (2k+1)-th rising clock edge after the loading edge. At that point `res_main` equals a_val^e_val mod m_val.
- R2: The loop length k may be any value from 1 to W, provided bit k-1 of the exponent is set. With k = 1 the result is a_val mod m_val.
- R3: A zero exponent bit leaves the accumulator unchanged, so exponents made mostly of zero bits still give the exact power.
- R4: When `mode` = 1 (dual), `res_alt` equals a_alt^e_alt mod m_alt. `res_main` is computed independently from the primary operands, and both finish on the same `done`.
- R5: When `mode` = 0 (checking), the alternate operands are ignored and `res_alt` equals `res_main` when `done` rises.
- R6: In checking mode with no fault injected, `err` stays 0 for the whole run.
- R7: In checking mode, a product fault that alters the primary power term sets `err`. The flag stays set until the next accepted `start`, and it reads 0 one cycle after that start.
- R8: In dual mode `err` stays 0 even when a fault is injected.
- R9: `done` still pulses for exactly one cycle at the normal time when a fault has been detected.
- R10: A `start` seen while a run is in progress is ignored. The run finishes with the result of the operands it was started with.
- R11: After reset `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin a run (taken only when idle) |
| mode | input | 1 | 0 = checking with redundant copy, 1 = two independent jobs |
| k_len | input | KW | Exponent length k, 1..W |
| a_val | input | W | Primary base, below m_val |
| e_val | input | W | Primary exponent, bit k-1 set |
| m_val | input | W | Primary modulus, above 1 |
| a_alt | input | W | Second-job base (dual mode) |
| e_alt | input | W | Second-job exponent (dual mode), bit k-1 set |
| m_alt | input | W | Second-job modulus (dual mode) |
| stuck_mask | input | 2W | Bits forced to one on the first multiplier's product |
| res_main | output | W | Primary result |
| res_alt | output | W | Redundant copy (checking) or second-job result (dual) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky mismatch flag |

## Verification
The range property on the result assumes the primary modulus is above 1 and the base is below it. The stimulus builds every modulus from 2 upwards and reduces every base by it first. The timing properties assume k lies between 1 and W with bit k-1 of each exponent set. Every directed and random job builds its exponents by forcing that bit and filling only the bits below it. The stuck mask is held at zero except in the two fault scenarios, and it is never changed during a run.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic {
    PM_CHECK = 1'b0,
    PM_DUAL  = 1'b1
  } pm_mode_e;
endpackage

// File: rtl/pm_mul.sv
module pm_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  input  logic [2*W-1:0] stuck,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  // Stuck-at-one mask overlays the true product.
  assign prod = (PW'(x) * PW'(y)) | stuck;
endmodule

// File: rtl/pm_red.sv
module pm_red #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] prod,
  input  logic [W-1:0]   m,
  output logic [W-1:0]   r
);
  localparam int PW = 2 * W;

  always_comb begin
    if (m == '0) r = '0;
    else         r = W'(prod % PW'(m));
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl #(
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] k_len,
  output logic          busy,
  output logic          phase,
  output logic [KW-1:0] cnt,
  output logic [KW-1:0] k_q,
  output logic          load,
  output logic          fin
);
  logic          busy_q, phase_q;
  logic [KW-1:0] cnt_q, kq;

  assign load  = start & ~busy_q;
  assign fin   = busy_q & ~phase_q & (cnt_q == kq);
  assign busy  = busy_q;
  assign phase = phase_q;
  assign cnt   = cnt_q;
  assign k_q   = kq;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      kq      <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      kq      <= k_len;
    end else if (busy_q) begin
      if (!phase_q) begin
        if (cnt_q == kq) busy_q <= 1'b0;
        else             phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        cnt_q   <= cnt_q + KW'(1);
      end
    end
  end
endmodule

// File: rtl/paired_modexp.sv
module paired_modexp
  import pm_pkg::*;
#(
  parameter int W  = 16,
  parameter int KW = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           mode,
  input  logic [KW-1:0]  k_len,
  input  logic [W-1:0]   a_val,
  input  logic [W-1:0]   e_val,
  input  logic [W-1:0]   m_val,
  input  logic [W-1:0]   a_alt,
  input  logic [W-1:0]   e_alt,
  input  logic [W-1:0]   m_alt,
  input  logic [2*W-1:0] stuck_mask,
  output logic [W-1:0]   res_main,
  output logic [W-1:0]   res_alt,
  output logic           done,
  output logic           err
);
  localparam int PW = 2 * W;

  logic          busy, phase, load, fin;
  logic [KW-1:0] cnt, k_q, cnt_m1;

  pm_ctrl #(.KW(KW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .k_len(k_len),
    .busy(busy), .phase(phase), .cnt(cnt), .k_q(k_q),
    .load(load), .fin(fin)
  );

  // Thread 0 state (p_q, b_q) and thread 1 state (pr_q, br_q)
  logic [W-1:0]  p_q, b_q, pr_q, br_q;
  logic [W-1:0]  ep_q, er_q, mp_q, mr_q;
  pm_mode_e      mode_q;
  logic [PW-1:0] prod_x, prod_y;
  logic          done_q, err_q;

  function automatic logic bit_at(input logic [W-1:0] v, input logic [KW-1:0] idx);
    logic b;
    b = 1'b0;
    for (int i = 0; i < W; i++)
      if (idx == KW'(i)) b = v[i];
    return b;
  endfunction

  // Unit input muxes: cycle 0 feeds thread 0, cycle 1 feeds thread 1.
  // Pair X forms thread-0 power and thread-1 accumulator; pair Y the reverse.
  logic [W-1:0]  mx_a, mx_b, my_a, my_b, red_m, rx, ry;
  logic [PW-1:0] mx_out, my_out;

  assign mx_a  = phase ? pr_q : p_q;
  assign mx_b  = phase ? br_q : p_q;
  assign my_a  = phase ? pr_q : p_q;
  assign my_b  = phase ? pr_q : b_q;
  assign red_m = phase ? mp_q : mr_q;

  pm_mul #(.W(W)) u_mul_x (.x(mx_a), .y(mx_b), .stuck(stuck_mask), .prod(mx_out));
  pm_mul #(.W(W)) u_mul_y (.x(my_a), .y(my_b), .stuck('0),         .prod(my_out));
  pm_red #(.W(W)) u_red_x (.prod(prod_x), .m(red_m), .r(rx));
  pm_red #(.W(W)) u_red_y (.prod(prod_y), .m(red_m), .r(ry));

  // Last pass always multiplies the accumulator in.
  logic         take_p, take_r, mismatch;
  logic [W-1:0] pr_next, br_next;

  assign cnt_m1   = cnt - KW'(1);
  assign take_p   = (cnt == k_q - KW'(1)) | bit_at(ep_q, cnt);
  assign take_r   = (cnt_m1 == k_q - KW'(1)) | bit_at(er_q, cnt_m1);
  assign pr_next  = ry;
  assign br_next  = take_r ? rx : br_q;
  assign mismatch = (pr_next != p_q) | (br_next != b_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q    <= '0;  b_q  <= '0;  pr_q <= '0;  br_q <= '0;
      ep_q   <= '0;  er_q <= '0;  mp_q <= '0;  mr_q <= '0;
      mode_q <= PM_CHECK;
      prod_x <= '0;  prod_y <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if (load) begin
        mode_q <= pm_mode_e'(mode);
        p_q    <= a_val;
        b_q    <= W'(1);
        ep_q   <= e_val;
        mp_q   <= m_val;
        pr_q   <= mode ? a_alt : a_val;
        br_q   <= W'(1);
        er_q   <= mode ? e_alt : e_val;
        mr_q   <= mode ? m_alt : m_val;
        err_q  <= 1'b0;
      end else if (busy) begin
        prod_x <= mx_out;
        prod_y <= my_out;
        if (phase) begin
          p_q <= rx;
          if (take_p) b_q <= ry;
        end else if (cnt != '0) begin
          pr_q <= pr_next;
          br_q <= br_next;
          if (mode_q == PM_CHECK && mismatch) err_q <= 1'b1;
        end
      end
    end
  end

  assign res_main = b_q;
  assign res_alt  = br_q;
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/pm_chk.sv
module pm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic         dual,
  input logic [W-1:0] res_main,
  input logic [W-1:0] mod_q
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !(start && !busy)) |=> err);

  // R8
  dual_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && dual) |-> !err);

  // R1
  res_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_main < mod_q));

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

bind paired_modexp pm_chk #(.W(W)) u_pm_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err(err), .dual(mode_q), .res_main(res_main), .mod_q(mp_q)
);

// File: tb/test_paired_modexp.sv
module test_paired_modexp;
  localparam int W  = 16;
  localparam int KW = $clog2(W + 1);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0;
  logic [KW-1:0] k_len = '0;
  logic [W-1:0]  a_val = '0, e_val = '0, m_val = '0;
  logic [W-1:0]  a_alt = '0, e_alt = '0, m_alt = '0;
  logic [2*W-1:0] stuck_mask = '0;
  logic [W-1:0]  res_main, res_alt;
  logic          done, err;

  int checks = 0, fails = 0;
  int lat;
  logic err_first;
  logic [31:0] seed = 32'h1234_5678;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paired_modexp #(.W(W)) i_paired_modexp (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .k_len(k_len),
    .a_val(a_val), .e_val(e_val), .m_val(m_val),
    .a_alt(a_alt), .e_alt(e_alt), .m_alt(m_alt), .stuck_mask(stuck_mask),
    .res_main(res_main), .res_alt(res_alt), .done(done), .err(err)
  );

  function automatic longint ref_pow(longint a, longint e, longint m);
    longint r = 1 % m, b = a % m;
    for (int i = 0; i < W; i++) begin
      if ((e >> i) & 1) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drives one run; poke raises a start with other operands mid-run.
  task automatic run(input logic md, input int k, input int a, input int e, input int m,
                     input int a2, input int e2, input int m2, input bit poke);
    @(negedge clk);
    mode = md; k_len = KW'(k);
    a_val = W'(a); e_val = W'(e); m_val = W'(m);
    a_alt = W'(a2); e_alt = W'(e2); m_alt = W'(m2);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    err_first = 1'b1;
    for (int guard = 0; guard < 200; guard++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1) err_first = err;
      if (done) break;
      if (poke && lat == 3) begin
        start = 1'b1; a_val = W'(a + 1); e_val = W'(e | 1);
      end else if (poke && lat == 4) begin
        start = 1'b0; a_val = W'(a); e_val = W'(e);
      end
    end
  endtask

  task automatic finish_all();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R11 done after reset", done, 0);
    check(err == 1'b0, "R11 err after reset", err, 0);
  endtask

  task automatic t_directed();
    longint exp;
    // 3^13 mod 17, k = 4
    run(1'b0, 4, 3, 13, 17, 0, 0, 0, 0);
    exp = ref_pow(3, 13, 17);
    check(lat == 9, "R1 latency k=4", lat, 9);
    check(res_main == exp, "R1 result 3^13 mod 17", res_main, exp);
    check(res_alt == res_main, "R5 copy equals main", res_alt, res_main);
    check(err == 1'b0, "R6 no error fault-free", err, 0);
    // k = 1
    run(1'b0, 1, 45, 1, 97, 0, 0, 0, 0);
    check(lat == 3, "R2 latency k=1", lat, 3);
    check(res_main == 45, "R2 k=1 result", res_main, 45);
    // full length, only top bit set
    run(1'b0, 16, 7, 16'h8000, 65521, 0, 0, 0, 0);
    exp = ref_pow(7, 32768, 65521);
    check(lat == 33, "R2 latency k=16", lat, 33);
    check(res_main == exp, "R3 zero bits hold accumulator", res_main, exp);
    // alternate operands ignored in checking mode
    run(1'b0, 5, 12, 21, 1000, 999, 31, 40000, 0);
    exp = ref_pow(12, 21, 1000);
    check(res_main == exp, "R5 alt operands ignored main", res_main, exp);
    check(res_alt == exp, "R5 alt operands ignored copy", res_alt, exp);
  endtask

  task automatic t_random();
    for (int n = 0; n < 24; n++) begin
      int m, a, k, e;
      longint exp;
      m = int'(rnd() % 32'd65534) + 2;
      a = int'(rnd() % 32'(m));
      k = int'(rnd() % 32'd16) + 1;
      e = (int'(rnd()) & ((1 << (k - 1)) - 1)) | (1 << (k - 1));
      run(1'b0, k, a, e, m, 0, 0, 0, 0);
      exp = ref_pow(a, e, m);
      check(res_main == exp, "R1 random result", res_main, exp);
      check(lat == 2 * k + 1, "R1 random latency", lat, 2 * k + 1);
      check(res_alt == res_main && err == 1'b0, "R6 random no mismatch", err, 0);
    end
  endtask

  task automatic t_dual();
    for (int n = 0; n < 6; n++) begin
      int m, a, m2, a2, k, e, e2;
      longint x1, x2;
      m  = int'(rnd() % 32'd65534) + 2;
      a  = int'(rnd() % 32'(m));
      m2 = int'(rnd() % 32'd65534) + 2;
      a2 = int'(rnd() % 32'(m2));
      k  = int'(rnd() % 32'd16) + 1;
      e  = (int'(rnd()) & ((1 << (k - 1)) - 1)) | (1 << (k - 1));
      e2 = (int'(rnd()) & ((1 << (k - 1)) - 1)) | (1 << (k - 1));
      run(1'b1, k, a, e, m, a2, e2, m2, 0);
      x1 = ref_pow(a, e, m);
      x2 = ref_pow(a2, e2, m2);
      check(res_main == x1, "R4 dual main result", res_main, x1);
      check(res_alt == x2, "R4 dual second result", res_alt, x2);
      check(lat == 2 * k + 1, "R4 dual latency", lat, 2 * k + 1);
    end
  endtask

  task automatic t_fault();
    stuck_mask = 32'h1;
    run(1'b0, 4, 6, 9, 101, 0, 0, 0, 0);
    check(err == 1'b1, "R7 fault detected", err, 1);
    check(lat == 9, "R9 done on time with fault", lat, 9);
    @(negedge clk);
    check(done == 1'b0, "R9 done single pulse", done, 0);
    check(err == 1'b1, "R7 err sticky while idle", err, 1);
    run(1'b1, 4, 6, 9, 101, 8, 11, 211, 0);
    check(err == 1'b0, "R8 dual ignores fault", err, 0);
    check(lat == 9, "R8 dual done with fault", lat, 9);
    stuck_mask = '0;
    run(1'b0, 4, 6, 9, 101, 0, 0, 0, 0);
    check(err_first == 1'b0, "R7 err cleared by start", err_first, 0);
    check(err == 1'b0, "R7 clean run after fault", err, 0);
  endtask

  task automatic t_busy_start();
    longint exp;
    run(1'b0, 6, 1234, 45, 30011, 0, 0, 0, 1);
    exp = ref_pow(1234, 45, 30011);
    check(res_main == exp, "R10 start while busy ignored", res_main, exp);
    check(lat == 13, "R10 latency unchanged", lat, 13);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_directed();
    t_random();
    t_dual();
    t_fault();
    t_busy_start();
    finish_all();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_all();
  end
endmodule